// File: doc/BRIEF.md
# Two-Dimensional Stream-to-Memory DMA Channel

This block is one DMA channel that moves data words between a set of stream ports and a shared memory bus. Software sets up the transfer through a small word-addressed register interface. The setup gives a start address, an inner count and stride, an outer count and stride, a port select and a configuration word. The channel then walks a two-dimensional address pattern. In the write direction it takes words from the selected receive port and stores them to memory. In the read direction it fetches words from memory and hands them out on the selected transmit port. A four-word holding FIFO decouples the stream side from the memory side.

The memory bus belongs to the processor. The channel may use it only in cycles that the processor leaves free, which it learns from a slot-grant input. The programmed parameters are kept apart from the live working registers. Software can therefore stage the next transfer while the current one runs. In continuous mode the channel reloads the working registers from the parameters when a pass ends and starts the next pass by itself. A completion flag drives an interrupt line. Software clears the flag by writing 1 to it.

Top module: `dma2d_chan`

## Requirements
- R1: After reset the status and current-address registers read 0, and `irq`, `mem_req`, every `rx_ready` bit and every `tx_valid` bit are low.
- R2: Register offsets are 0 start address, 1 inner count, 2 inner stride, 3 outer count, 4 outer stride, 5 configuration and 6 port select. Offsets 8, 9 and 10 are the read-only current address, inner count and outer count, and offset 11 is status. Parameter registers read back what was written. Writes to offsets 8 to 10 are ignored.
- R3: Configuration bit 0 is enable. Writing it as 1 while idle starts a transfer, and status bit 1 (running) goes high. Writing it as 0 stops the channel. A configuration write with bit 0 set while the channel is running is ignored.
- R4: `mem_req` is high only in cycles where `mem_gnt` is high. With `mem_gnt` held low, no memory access takes place.
- R5: Word k goes to an address that starts at the start address. The address grows by the inner stride within a row and by the outer stride from the last word of a row to the first word of the next row. Each row has inner-count words, and there are outer-count rows.
- R6: The holding FIFO stores 4 words. Once it is full, `rx_ready` is low.
- R7: Configuration bit 4 set to 0 selects stop mode. After the last word the channel stops, running reads 0 and status bit 0 (done) reads 1.
- R8: With configuration bit 4 set to 1, the working registers reload from the parameters after the last word, and the next pass starts while running stays 1.
- R9: Completion sets status bit 0. `irq` is the done bit gated by configuration bit 2. Writing 1 to status bit 0 clears the done bit.
- R10: Configuration bit 3 (restart), written together with a start, discards any words left in the FIFO. Without it, leftover words are used first.
- R11: The port-select value picks which index of `rx_valid`/`rx_ready`/`tx_valid`/`tx_ready` serves the transfer, and 0 selects port 0. The other indices stay idle.
- R12: Parameter writes during a transfer leave the running pass unchanged. They take effect at the next start or continuous reload.
- R13: Configuration bit 1 set to 1 means stream-to-memory (memory write). Set to 0 it means memory-to-stream: fetched words appear on `tx_data` in address-walk order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_gnt | input | 1 | Processor leaves this cycle free for the channel |
| mem_req | output | 1 | Channel accesses memory this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the access cycle |
| rx_valid | input | NP | Receive port valid, one bit per port |
| rx_data | input | DW | Receive data, shared by all ports |
| rx_ready | output | NP | Receive port ready |
| tx_valid | output | NP | Transmit port valid |
| tx_data | output | DW | Transmit data |
| tx_ready | input | NP | Transmit port ready |

## Verification
The hardest states to reach from the ports are leftover words sitting in the FIFO when a new transfer starts, and a parameter rewrite landing while a pass is still live. The bench creates the first by holding the slot grant low while the receive port overruns, so the FIFO fills. It then halts and restarts the channel both with and without the restart bit. For the second, it starts a continuous pass with the grant withheld, rewrites the start address and stride, and only then opens the grant. Memory contents then show which parameters each pass actually used.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam logic [3:0] RA_START = 4'd0;
  localparam logic [3:0] RA_ICNT  = 4'd1;
  localparam logic [3:0] RA_IMOD  = 4'd2;
  localparam logic [3:0] RA_OCNT  = 4'd3;
  localparam logic [3:0] RA_OMOD  = 4'd4;
  localparam logic [3:0] RA_CFG   = 4'd5;
  localparam logic [3:0] RA_PMAP  = 4'd6;
  localparam logic [3:0] RA_CADDR = 4'd8;
  localparam logic [3:0] RA_CICNT = 4'd9;
  localparam logic [3:0] RA_COCNT = 4'd10;
  localparam logic [3:0] RA_STAT  = 4'd11;

  localparam int CFGW       = 5;
  localparam int CB_EN      = 0;
  localparam int CB_DIR     = 1;
  localparam int CB_IRQEN   = 2;
  localparam int CB_RESTART = 3;
  localparam int CB_CONT    = 4;
endpackage

// File: rtl/dma2d_fifo.sv
module dma2d_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [PW:0]   wp, rp;
  logic          do_push, do_pop;

  assign full    = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  assign empty   = (wp == rp);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store[rp[PW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) store[wp[PW-1:0]] <= din;
  end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] prm_start,
  input  logic [CW-1:0] prm_icnt,
  input  logic [AW-1:0] prm_imod,
  input  logic [CW-1:0] prm_ocnt,
  input  logic [AW-1:0] prm_omod,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_icnt,
  output logic [CW-1:0] cur_ocnt,
  output logic          is_last
);
  typedef struct packed {
    logic [AW-1:0] addr;
    logic [CW-1:0] icnt;
    logic [CW-1:0] ocnt;
  } pos_t;

  // Advance one word: inner stride within a row, outer stride between rows.
  function automatic pos_t next_pos(pos_t p, logic [CW-1:0] row_len,
                                    logic [AW-1:0] imod, logic [AW-1:0] omod);
    pos_t n;
    if (p.icnt > CW'(1)) begin
      n = '{addr: p.addr + imod, icnt: p.icnt - 1'b1, ocnt: p.ocnt};
    end else if (p.ocnt > CW'(1)) begin
      n = '{addr: p.addr + omod, icnt: row_len, ocnt: p.ocnt - 1'b1};
    end else begin
      n = '{addr: p.addr + imod, icnt: '0, ocnt: '0};
    end
    return n;
  endfunction

  pos_t          pos_q;
  logic [CW-1:0] w_icnt;
  logic [AW-1:0] w_imod, w_omod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      w_icnt <= '0;
      w_imod <= '0;
      w_omod <= '0;
    end else if (load) begin
      pos_q  <= '{addr: prm_start, icnt: prm_icnt, ocnt: prm_ocnt};
      w_icnt <= prm_icnt;
      w_imod <= prm_imod;
      w_omod <= prm_omod;
    end else if (step) begin
      pos_q <= next_pos(pos_q, w_icnt, w_imod, w_omod);
    end
  end

  assign cur_addr = pos_q.addr;
  assign cur_icnt = pos_q.icnt;
  assign cur_ocnt = pos_q.ocnt;
  assign is_last  = (pos_q.icnt <= CW'(1)) && (pos_q.ocnt <= CW'(1));
endmodule

// File: rtl/dma2d_chan.sv
module dma2d_chan
  import dma2d_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int NP    = 2,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  input  logic          mem_gnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic [NP-1:0] rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic [NP-1:0] rx_ready,
  output logic [NP-1:0] tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic [NP-1:0] tx_ready
);
  localparam int SW = (NP > 1) ? $clog2(NP) : 1;

  // programmed parameters
  logic [AW-1:0]   prm_start, prm_imod, prm_omod;
  logic [CW-1:0]   prm_icnt, prm_ocnt;
  logic [CFGW-1:0] cfg_q;
  logic [SW-1:0]   pmap_q, cur_sel;
  logic            running_q, done_q;

  // named internal events
  logic cfg_wr, start_evt, halt_evt, xfer, last_xfer, reload, flush;
  logic fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic rx_fire, tx_fire, is_last, dir, cont, irq_en;
  logic [NP-1:0]   sel_oh;
  logic [DW-1:0]   fifo_dout;
  logic [AW-1:0]   cur_addr;
  logic [CW-1:0]   cur_icnt, cur_ocnt;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata;

  assign dir    = cfg_q[CB_DIR];
  assign cont   = cfg_q[CB_CONT];
  assign irq_en = cfg_q[CB_IRQEN];

  assign cfg_wr    = reg_we && (reg_addr == RA_CFG);
  assign start_evt = cfg_wr && reg_wdata[CB_EN] && !running_q;
  assign halt_evt  = cfg_wr && !reg_wdata[CB_EN] && running_q;
  assign flush     = start_evt && reg_wdata[CB_RESTART];

  assign sel_oh = (32'(cur_sel) < NP) ? (NP'(1) << cur_sel) : '0;

  // memory side: only in granted slots
  assign mem_req   = running_q && mem_gnt && (dir ? !fifo_empty : !fifo_full);
  assign mem_we    = dir;
  assign mem_addr  = cur_addr;
  assign mem_wdata = fifo_dout;
  assign xfer      = mem_req;
  assign last_xfer = xfer && is_last;
  assign reload    = start_evt || (last_xfer && cont);

  // stream side
  assign rx_ready = (running_q && dir && !fifo_full) ? sel_oh : '0;
  assign rx_fire  = |(rx_ready & rx_valid);
  assign tx_valid = (!dir && !fifo_empty) ? sel_oh : '0;
  assign tx_data  = fifo_dout;
  assign tx_fire  = |(tx_valid & tx_ready);

  assign fifo_push = dir ? rx_fire : xfer;
  assign fifo_pop  = dir ? xfer : tx_fire;

  dma2d_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(fifo_push), .din(dir ? rx_data : mem_rdata),
    .pop(fifo_pop), .dout(fifo_dout),
    .full(fifo_full), .empty(fifo_empty)
  );

  dma2d_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(reload), .step(xfer),
    .prm_start(prm_start), .prm_icnt(prm_icnt), .prm_imod(prm_imod),
    .prm_ocnt(prm_ocnt), .prm_omod(prm_omod),
    .cur_addr(cur_addr), .cur_icnt(cur_icnt), .cur_ocnt(cur_ocnt),
    .is_last(is_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prm_start <= '0;
      prm_icnt  <= '0;
      prm_imod  <= '0;
      prm_ocnt  <= '0;
      prm_omod  <= '0;
      cfg_q     <= '0;
      pmap_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_START: prm_start <= reg_wdata[AW-1:0];
        RA_ICNT:  prm_icnt  <= reg_wdata[CW-1:0];
        RA_IMOD:  prm_imod  <= reg_wdata[AW-1:0];
        RA_OCNT:  prm_ocnt  <= reg_wdata[CW-1:0];
        RA_OMOD:  prm_omod  <= reg_wdata[AW-1:0];
        RA_CFG:   if (!running_q || !reg_wdata[CB_EN]) cfg_q <= reg_wdata[CFGW-1:0];
        RA_PMAP:  pmap_q    <= reg_wdata[SW-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      cur_sel   <= '0;
    end else begin
      if (start_evt) begin
        running_q <= 1'b1;
        cur_sel   <= pmap_q;
      end else if (halt_evt || (last_xfer && !cont)) begin
        running_q <= 1'b0;
      end
      if (last_xfer) done_q <= 1'b1;
      else if (reg_we && reg_addr == RA_STAT && reg_wdata[0]) done_q <= 1'b0;
    end
  end

  assign irq = done_q && irq_en;

  always_comb begin
    case (reg_addr)
      RA_START: reg_rdata = DW'(prm_start);
      RA_ICNT:  reg_rdata = DW'(prm_icnt);
      RA_IMOD:  reg_rdata = DW'(prm_imod);
      RA_OCNT:  reg_rdata = DW'(prm_ocnt);
      RA_OMOD:  reg_rdata = DW'(prm_omod);
      RA_CFG:   reg_rdata = DW'(cfg_q);
      RA_PMAP:  reg_rdata = DW'(pmap_q);
      RA_CADDR: reg_rdata = DW'(cur_addr);
      RA_CICNT: reg_rdata = DW'(cur_icnt);
      RA_COCNT: reg_rdata = DW'(cur_ocnt);
      RA_STAT:  reg_rdata = DW'({running_q, done_q});
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma2d_chan_chk.sv
module dma2d_chan_chk #(
  parameter int AW = 16,
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [NP-1:0] rx_ready,
  input logic [NP-1:0] tx_valid,
  input logic          irq,
  input logic          running_q,
  input logic          last_xfer,
  input logic          halt_evt,
  input logic          cont,
  input logic          irq_en,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          start_evt,
  input logic          flush,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] prm_start
);
  AST_REQ_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_gnt); // R4
  AST_REQ_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> running_q); // R3
  AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_ready) && $onehot0(tx_valid)); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (rx_ready == '0)); // R6
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && !cont) |=> !running_q); // R7
  AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && cont && !halt_evt) |=> (running_q && cur_addr == $past(prm_start))); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && irq_en && !halt_evt) |=> irq); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && flush) |=> fifo_empty); // R10
endmodule

bind dma2d_chan dma2d_chan_chk #(.AW(AW), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq),
  .running_q(running_q), .last_xfer(last_xfer), .halt_evt(halt_evt),
  .cont(cont), .irq_en(irq_en), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .start_evt(start_evt), .flush(flush), .cur_addr(cur_addr), .prm_start(prm_start)
);

// File: tb/test_dma2d_chan.sv
module test_dma2d_chan;
  localparam int DW = 32, AW = 16, NP = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic          irq, mem_gnt = 1'b0, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, rx_data = '0, tx_data;
  logic [NP-1:0] rx_valid = '0, rx_ready, tx_valid, tx_ready = '0;

  int n_chk = 0, n_err = 0, cycles = 0, r4_bad = 0, n_acc = 0;
  bit gnt_rand = 0, gnt_force = 0, tx0_seen = 0;
  logic [31:0] mem [256];
  logic [31:0] got [8];

  always #10 clk = ~clk;

  dma2d_chan #(.DW(DW), .AW(AW), .NP(NP)) i_dma2d_chan (.*);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      n_acc++;
      if (!mem_gnt) r4_bad++;
    end
    mem_gnt <= gnt_rand ? 1'($urandom % 2) : gnt_force;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(4'd11, s); while (s[1]);
  endtask

  // k-th address of a 2D walk, computed with nested loops
  function automatic int exp_addr(int st, int ic, int im, int oc, int om, int k);
    int a = st, n = 0;
    for (int o = 0; o < oc; o++)
      for (int i = 0; i < ic; i++) begin
        if (n == k) return a & 255;
        n++;
        a += (i == ic - 1) ? om : im;
      end
    return -1;
  endfunction

  task automatic feed(input int port, input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      bit acc = 0;
      while (!acc) begin
        @(negedge clk);
        rx_valid = ($urandom % 4 != 0) ? NP'(1 << port) : '0;
        rx_data = base + k;
        #1 acc = rx_valid[port] && rx_ready[port];
      end
    end
    @(negedge clk); rx_valid = '0;
  endtask

  task automatic collect(input int port, input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      tx_ready = ($urandom % 3 != 0) ? NP'(1 << port) : '0;
      #1;
      if (tx_valid[0] && port != 0) tx0_seen = 1;
      if (tx_valid[port] && tx_ready[port]) begin got[k] = tx_data; k++; end
    end
    @(negedge clk); tx_ready = '0;
  endtask

  initial begin
    logic [31:0] v, base;
    int acc;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd11, v); chk("R1 status", v, 0);
    rd(4'd8, v);  chk("R1 cur addr", v, 0);
    chk("R1 irq/req/ready/valid", {irq, mem_req, rx_ready, tx_valid}, 0);

    // R2 readback and read-only current registers
    wr(4'd2, 32'h0000_0007); rd(4'd2, v); chk("R2 inner stride readback", v, 7);
    wr(4'd8, 32'h0000_0055); rd(4'd8, v); chk("R2 cur addr read-only", v, 0);

    // R5/R7/R9 stream-to-memory, stop mode, random slots
    gnt_rand = 1;
    base = $urandom & 32'hFFFF_0000;
    wr(4'd0, 32'h10); wr(4'd1, 3); wr(4'd2, 1); wr(4'd3, 2); wr(4'd4, 5); wr(4'd6, 0);
    wr(4'd5, 32'h07);            // enable, to-memory, irq enable
    feed(0, base, 6);
    wait_idle();
    for (int k = 0; k < 6; k++)
      chk("R5 2D address walk", mem[exp_addr(16, 3, 1, 2, 5, k)], base + k);
    rd(4'd11, v); chk("R7 stop mode halts, done set", v, 32'h1);
    #1 chk("R9 irq raised", {31'b0, irq}, 1);
    wr(4'd11, 1); #1 chk("R9 irq cleared by W1C", {31'b0, irq}, 0);

    // R6 FIFO full with no slots
    gnt_rand = 0; gnt_force = 0;
    wr(4'd0, 32'h80); wr(4'd1, 1); wr(4'd3, 1);
    wr(4'd5, 32'h03);
    rd(4'd11, v); chk("R3 running after start", v, 32'h2);
    acc = 0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); rx_valid = 2'b01; rx_data = 32'hA0 + acc;
      #1 if (rx_ready[0]) acc++;
    end
    @(negedge clk); rx_valid = '0;
    chk("R6 fifo depth 4", acc, 4);
    #1 chk("R6 ready low when full", {30'b0, rx_ready}, 0);
    chk("R4 no write without slot", mem[8'h80], 0);
    wr(4'd5, 32'h02);
    rd(4'd11, v); chk("R3 halt clears running", v[1], 0);

    // R10 leftover words used without restart, discarded with it
    gnt_rand = 1;
    wr(4'd5, 32'h03);
    wait_idle();
    chk("R10 stale word without restart", mem[8'h80], 32'hA0);
    wr(4'd0, 32'h90); wr(4'd1, 2);
    wr(4'd5, 32'h0B);
    feed(0, 32'hB0, 2);
    wait_idle();
    chk("R10 restart flushes, word0", mem[8'h90], 32'hB0);
    chk("R10 restart flushes, word1", mem[8'h91], 32'hB1);

    // R13/R11 memory-to-stream on port 1
    for (int k = 0; k < 6; k++) mem[exp_addr(32, 3, 2, 2, 7, k)] = 32'hC000 + k * 3;
    wr(4'd0, 32'h20); wr(4'd1, 3); wr(4'd2, 2); wr(4'd3, 2); wr(4'd4, 7); wr(4'd6, 1);
    wr(4'd5, 32'h01);
    collect(1, 6);
    for (int k = 0; k < 6; k++) chk("R13 fetched word order", got[k], 32'hC000 + k * 3);
    chk("R11 port 0 idle", {31'b0, tx0_seen}, 0);
    wait_idle();
    rd(4'd11, v); chk("R7 done after read pass", v, 32'h1);
    wr(4'd11, 1);

    // R8/R12 continuous mode, parameters rewritten mid-pass
    gnt_rand = 0; gnt_force = 0;
    wr(4'd6, 0); wr(4'd0, 32'h40); wr(4'd1, 2); wr(4'd2, 1); wr(4'd3, 1); wr(4'd4, 0);
    wr(4'd5, 32'h17);
    wr(4'd0, 32'h50); wr(4'd2, 3);
    rd(4'd8, v); chk("R12 current addr unchanged", v, 32'h40);
    rd(4'd0, v); chk("R2 start readback", v, 32'h50);
    gnt_rand = 1;
    feed(0, 32'hD0, 2);
    while (!irq) @(negedge clk);
    chk("R12 pass1 word0", mem[8'h40], 32'hD0);
    chk("R12 pass1 word1", mem[8'h41], 32'hD1);
    rd(4'd11, v); chk("R8 still running after pass", v, 32'h3);
    wr(4'd11, 1);
    feed(0, 32'hD2, 2);
    while (!irq) @(negedge clk);
    wr(4'd5, 32'h00);
    chk("R8 reload start", mem[8'h50], 32'hD2);
    chk("R8 reload stride", mem[8'h53], 32'hD3);
    rd(4'd11, v); chk("R3 halted", v[1], 0);

    chk("R4 access only in slots", r4_bad, 0);
    chk("R4 accesses happened", {31'b0, n_acc > 0}, 1);
    finish_run();
  end
endmodule